// File: doc/BRIEF.md
# Byte-Serial Register/Memory Transfer Engine

This engine copies a run of bytes between a register file of 32 words (32 bits each) and a memory that is addressed in bytes. A command gives five things: a direction (store: registers to memory; load: memory to registers), a start byte address, a start register, a start byte lane inside that register, and a byte count. The engine moves one byte per beat. Each beat raises the memory address by one and steps to the next lane. When the lane passes the top of a register, it goes back to lane 0 of the next register. The ordering is little-endian: the byte at the start address pairs with the start lane.

The register file and the memory stay outside the block. The engine drives a register port with a register index, a write strobe per lane, and a replicated write byte, and it reads the addressed word back combinationally. The memory port is one byte wide, and its read data is also combinational.

The engine checks every command before any data moves. Three guards can refuse a command:
- A null-address trap, which can be switched on or off.
- A guard on the instruction space, which can be switched on or off.
- A check for overrun of the register file.

A refused command ends with a single error code and moves nothing. An accepted command waits two extra cycles and then runs its beats. `done` pulses for one cycle at the end of every command.

Top module: `regmem_byte_mover`

## Requirements
- R1: An accepted command issues exactly `cmd_len` memory beats on consecutive cycles. The first beat uses `cmd_addr` and each later beat uses the previous address plus one.
- R2: Beat k (counting from 0) uses lane (`cmd_lane`+k) mod 4 of register `cmd_reg` + (`cmd_lane`+k) div 4. The byte at `cmd_addr` pairs with lane `cmd_lane`, and lane i holds data bits [8i+7:8i].
- R3: A command with 4*`cmd_reg` + `cmd_lane` + `cmd_len` > 128 ends with `err_code` 3 and issues no beats. A sum of exactly 128 is accepted.
- R4: If `null_trap_en` is 1 and `cmd_addr` < 4, the command ends with `err_code` 1 and issues no beats. Address 4 is accepted, and with the enable at 0 address 0 is accepted.
- R5: If `space_guard_en` is 1, a command ends with `err_code` 2 and issues no beats when `cmd_addr` >= `code_base` or when `cmd_addr` + `cmd_len` > `code_base`. Ending exactly at `code_base` is accepted.
- R6: Each load beat drives `rf_we` with exactly one bit set in `rf_lane_we`, the bit for the beat's lane. The other lanes of the register keep their values.
- R7: For an accepted command of N > 0 bytes, `done` is high in cycle N+3 after the cycle in which `start` was sampled. The first beat comes in cycle 3. Out of reset, `busy`, `done` and `mem_req` are low.
- R8: When more than one guard would refuse a command, only one code is reported: null trap (1) wins over the space guard (2), which wins over overrun (3). `err_code` is 0 for a command that ran.
- R9: A command with `cmd_len` 0 that passes the guards gives `done` with `err_code` 0 in the next cycle and issues no beats.
- R10: A store beat drives `mem_we` high with the byte of the beat's register lane on `mem_wdata` and does not write the register file. A load beat keeps `mem_we` low.
- R11: `start` is ignored while `busy` is high. The command in flight keeps its latched fields even if the command inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Command strobe, sampled while idle |
| cmd_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| cmd_addr | input | 16 | Start byte address |
| cmd_reg | input | 5 | Start register number |
| cmd_lane | input | 2 | Start byte lane in that register |
| cmd_len | input | 8 | Number of bytes to move |
| null_trap_en | input | 1 | Enables the null-address trap |
| space_guard_en | input | 1 | Enables the instruction-space guard |
| code_base | input | 16 | First byte address of instruction space |
| busy | output | 1 | High during the wait and beat phases |
| done | output | 1 | One-cycle end-of-command pulse |
| err_code | output | 2 | 0 ok, 1 null trap, 2 space guard, 3 register overrun; valid with done |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Memory write for this beat |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Store byte |
| mem_rdata | input | 8 | Load byte, combinational from mem_addr |
| rf_idx | output | 5 | Register index of this beat |
| rf_rdata | input | 32 | Register word at rf_idx, combinational |
| rf_we | output | 1 | Register write for this beat |
| rf_lane_we | output | 4 | Per-lane register write strobes |
| rf_wdata | output | 32 | Load byte replicated to all lanes |

## Verification
Some properties are checked on every cycle:
- The address steps by one between consecutive beats.
- A lane wrap moves to lane 0 of the next register.
- Each load beat writes exactly one lane and never writes memory.
- `done` follows the last beat with no gap.
- A refused command is never preceded by a beat.
- `done` and `busy` are never high together.

Other behaviour only the bench scenarios can show:
- The exact thresholds of the three guards, including the accepted boundary values.
- The priority between errors when several guards fail at once.
- The start cycle of the wait and the count of beats.
- The preserved neighbouring lanes in the register file.
- A second `start` during a transfer being ignored.

// File: rtl/regmem_pkg.sv
package regmem_pkg;

  // Result of a command; the numeric codes are visible on err_code.
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NULL    = 2'd1,
    ERR_SPACE   = 2'd2,
    ERR_OVERRUN = 2'd3
  } xfer_err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BEAT = 2'd2,
    ST_DONE = 2'd3
  } xfer_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/regmem_guard.sv
module regmem_guard
  import regmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 8,
  parameter int RF_DEPTH = 32,
  parameter int LANES    = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LEN_W-1:0]            nbytes,
  input  logic [$clog2(RF_DEPTH)-1:0] reg_num,
  input  logic [$clog2(LANES)-1:0]    lane,
  input  logic                        null_en,
  input  logic                        space_en,
  input  logic [ADDR_W-1:0]           marker,
  output xfer_err_e                   err
);

  localparam int RF_BYTES  = RF_DEPTH * LANES;
  localparam int SPAN_W    = max2(ADDR_W, LEN_W) + 1;
  localparam int OVR_W     = max2($clog2(RF_BYTES) + 1, LEN_W) + 1;
  localparam int NULL_SPAN = LANES;

  logic [SPAN_W-1:0] end_addr;
  logic [OVR_W-1:0]  rf_end;
  logic              hit_null;
  logic              hit_space;
  logic              hit_ovr;

  always_comb begin
    end_addr  = SPAN_W'(addr) + SPAN_W'(nbytes);
    rf_end    = OVR_W'(reg_num) * OVR_W'(LANES) + OVR_W'(lane) + OVR_W'(nbytes);
    hit_null  = null_en && (addr < ADDR_W'(NULL_SPAN));
    hit_space = space_en && ((addr >= marker) || (end_addr > SPAN_W'(marker)));
    hit_ovr   = rf_end > OVR_W'(RF_BYTES);
  end

  // Fixed priority: null trap, then space guard, then register overrun.
  always_comb begin
    if (hit_null)       err = ERR_NULL;
    else if (hit_space) err = ERR_SPACE;
    else if (hit_ovr)   err = ERR_OVERRUN;
    else                err = ERR_NONE;
  end

endmodule

// File: rtl/regmem_walker.sv
module regmem_walker #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 5,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [IDX_W-1:0]         reg_i,
  input  logic [$clog2(LANES)-1:0] lane_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [IDX_W-1:0]         reg_o,
  output logic [$clog2(LANES)-1:0] lane_o,
  output logic                     last_o
);

  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  reg_q,  reg_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              cnt_en;

  assign cnt_en = load | step;

  always_comb begin
    addr_d = addr_q;
    reg_d  = reg_q;
    lane_d = lane_q;
    left_d = left_q;
    if (load) begin
      addr_d = addr_i;
      reg_d  = reg_i;
      lane_d = lane_i;
      left_d = len_i;
    end else if (step) begin
      addr_d = addr_q + ADDR_W'(1);
      left_d = left_q - LEN_W'(1);
      if (lane_q == TOP_LANE) begin
        lane_d = '0;
        reg_d  = reg_q + IDX_W'(1);
      end else begin
        lane_d = lane_q + LANE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      reg_q  <= '0;
      lane_q <= '0;
      left_q <= '0;
    end else if (cnt_en) begin
      addr_q <= addr_d;
      reg_q  <= reg_d;
      lane_q <= lane_d;
      left_q <= left_d;
    end
  end

  assign addr_o = addr_q;
  assign reg_o  = reg_q;
  assign lane_o = lane_q;
  assign last_o = (left_q == LEN_W'(1));

  // R1: every beat advances the byte address by one
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

  // R2: leaving the top lane returns to lane 0 of the next register
  a_r2_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane_o == TOP_LANE) |=> (lane_o == '0 && reg_o == $past(reg_o) + IDX_W'(1)));

  // R2: inside a register the lane rises and the register stays
  a_r2_lane_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane_o != TOP_LANE) |=> (lane_o == $past(lane_o) + LANE_W'(1) && $stable(reg_o)));

endmodule

// File: rtl/regmem_lane_mux.sv
module regmem_lane_mux #(
  parameter int REG_W = 32,
  parameter int LANES = REG_W / 8
) (
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [REG_W-1:0]         rf_rdata,
  input  logic [7:0]               mem_rdata,
  output logic [7:0]               store_byte,
  output logic [LANES-1:0]         lane_we,
  output logic [REG_W-1:0]         wr_word
);

  localparam int LANE_W = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g]         = (lane == LANE_W'(g));
    assign wr_word[g*8 +: 8]  = mem_rdata;
  end

  always_comb begin
    store_byte = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LANE_W'(k)) store_byte = rf_rdata[k*8 +: 8];
    end
  end

endmodule

// File: rtl/regmem_byte_mover.sv
module regmem_byte_mover
  import regmem_pkg::*;
#(
  parameter int RF_DEPTH  = 32,
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int EXTRA_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          cmd_store,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [$clog2(RF_DEPTH)-1:0]   cmd_reg,
  input  logic [$clog2(REG_W/8)-1:0]    cmd_lane,
  input  logic [LEN_W-1:0]              cmd_len,
  input  logic                          null_trap_en,
  input  logic                          space_guard_en,
  input  logic [ADDR_W-1:0]             code_base,
  output logic                          busy,
  output logic                          done,
  output logic [1:0]                    err_code,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [7:0]                    mem_wdata,
  input  logic [7:0]                    mem_rdata,
  output logic [$clog2(RF_DEPTH)-1:0]   rf_idx,
  input  logic [REG_W-1:0]              rf_rdata,
  output logic                          rf_we,
  output logic [REG_W/8-1:0]            rf_lane_we,
  output logic [REG_W-1:0]              rf_wdata
);

  localparam int LANES  = REG_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = $clog2(RF_DEPTH);
  localparam int WAIT_W = (EXTRA_LAT > 1) ? $clog2(EXTRA_LAT) : 1;

  xfer_state_e       state_q, state_d;
  xfer_err_e         err_q, err_d, chk_err;
  logic              store_q, store_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              accept, launch, step, last_beat;
  logic [LANE_W-1:0] cur_lane;
  logic [LANES-1:0]  lane_we;
  logic              ctl_en;

  regmem_guard #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RF_DEPTH(RF_DEPTH), .LANES(LANES)
  ) u_guard (
    .addr     (cmd_addr),
    .nbytes   (cmd_len),
    .reg_num  (cmd_reg),
    .lane     (cmd_lane),
    .null_en  (null_trap_en),
    .space_en (space_guard_en),
    .marker   (code_base),
    .err      (chk_err)
  );

  regmem_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .LANES(LANES)
  ) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (launch),
    .step   (step),
    .addr_i (cmd_addr),
    .reg_i  (cmd_reg),
    .lane_i (cmd_lane),
    .len_i  (cmd_len),
    .addr_o (mem_addr),
    .reg_o  (rf_idx),
    .lane_o (cur_lane),
    .last_o (last_beat)
  );

  regmem_lane_mux #(
    .REG_W(REG_W), .LANES(LANES)
  ) u_mux (
    .lane       (cur_lane),
    .rf_rdata   (rf_rdata),
    .mem_rdata  (mem_rdata),
    .store_byte (mem_wdata),
    .lane_we    (lane_we),
    .wr_word    (rf_wdata)
  );

  assign accept = (state_q == ST_IDLE) && start;
  assign launch = accept && (chk_err == ERR_NONE) && (cmd_len != '0);
  assign step   = (state_q == ST_BEAT);

  // Next-state process
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    store_d = store_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          err_d   = chk_err;
          store_d = cmd_store;
          if (!launch) begin
            state_d = ST_DONE;
          end else if (EXTRA_LAT == 0) begin
            state_d = ST_BEAT;
          end else begin
            state_d = ST_WAIT;
            wait_d  = WAIT_W'(EXTRA_LAT - 1);
          end
        end
      end
      ST_WAIT: begin
        if (wait_q == '0) state_d = ST_BEAT;
        else              wait_d  = wait_q - WAIT_W'(1);
      end
      ST_BEAT: begin
        if (last_beat) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_q != ST_IDLE) || start;

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      store_q <= 1'b0;
      wait_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      err_q   <= err_d;
      store_q <= store_d;
      wait_q  <= wait_d;
    end
  end

  assign busy       = (state_q == ST_WAIT) || (state_q == ST_BEAT);
  assign done       = (state_q == ST_DONE);
  assign err_code   = err_q;
  assign mem_req    = step;
  assign mem_we     = step && store_q;
  assign rf_we      = step && !store_q;
  assign rf_lane_we = rf_we ? lane_we : '0;

  // R3: a refused command ends without a beat just before it
  a_r3_no_move_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> !$past(mem_req));

  // R7: done follows the last beat with no gap
  a_r7_done_after_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> done);

  // R6: a load beat writes exactly one lane and no memory
  a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($countones(rf_lane_we) == 1 && mem_req && !mem_we));

  // R10: a store beat never writes the register file
  a_r10_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!rf_we && rf_lane_we == '0));

  // R11: completion and activity never overlap
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/regmem_byte_mover_test.sv
module regmem_byte_mover_test;

  localparam int EXTRA = 2;
  localparam int MEMSZ = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cmd_store, null_trap_en, space_guard_en;
  logic [15:0] cmd_addr, code_base;
  logic [4:0]  cmd_reg;
  logic [1:0]  cmd_lane;
  logic [7:0]  cmd_len;
  logic        busy, done, mem_req, mem_we, rf_we;
  logic [1:0]  err_code;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  rf_idx;
  logic [31:0] rf_rdata, rf_wdata;
  logic [3:0]  rf_lane_we;

  logic [31:0] rf [32];
  logic [7:0]  dm [MEMSZ];
  logic [31:0] exp_rf [32];
  logic [7:0]  exp_dm [MEMSZ];

  typedef struct {
    bit          st;
    logic [15:0] a;
    logic [4:0]  r;
    logic [1:0]  l;
    logic [7:0]  b;
  } beat_t;
  beat_t q[$];

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  regmem_byte_mover uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_store(cmd_store),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_lane(cmd_lane), .cmd_len(cmd_len),
    .null_trap_en(null_trap_en), .space_guard_en(space_guard_en), .code_base(code_base),
    .busy(busy), .done(done), .err_code(err_code),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_lane_we(rf_lane_we), .rf_wdata(rf_wdata)
  );

  assign rf_rdata  = rf[rf_idx];
  assign mem_rdata = dm[mem_addr[9:0]];

  always @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (rf_we && rf_lane_we[k]) rf[rf_idx][k*8 +: 8] <= rf_wdata[k*8 +: 8];
    if (mem_req && mem_we) dm[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the expected beat for every beat the design issues
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_req === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected beat at addr", longint'(mem_addr), 0);
      end else begin
        beat_t e;
        e = q.pop_front();
        check(mem_addr == e.a, "R1", "beat address", longint'(mem_addr), longint'(e.a));
        check(rf_idx == e.r, "R2", "beat register", longint'(rf_idx), longint'(e.r));
        check(mem_we == e.st, "R10", "mem_we", longint'(mem_we), longint'(e.st));
        if (e.st) begin
          check(mem_wdata == e.b && !rf_we, "R10", "store byte", longint'(mem_wdata), longint'(e.b));
        end else begin
          check(rf_we && rf_lane_we == (4'b1 << e.l), "R6", "lane strobe",
                longint'(rf_lane_we), longint'(4'b1 << e.l));
          check(rf_wdata[e.l*8 +: 8] == e.b, "R2", "load byte",
                longint'(rf_wdata[e.l*8 +: 8]), longint'(e.b));
        end
      end
    end
  end

  // Driver: computes the expected beats and final state, runs one command
  task automatic run_cmd(input string req, input bit st, input logic [15:0] a,
                         input int r, input int l, input int n,
                         input int exp_err, input bit poke);
    int c;
    int exp_c;
    bit same;
    exp_rf = rf;
    exp_dm = dm;
    if (exp_err == 0) begin
      for (int i = 0; i < n; i++) begin
        beat_t e;
        e.st = st;
        e.a  = a + 16'(i);
        e.r  = 5'(r + (l + i) / 4);
        e.l  = 2'((l + i) % 4);
        if (st) begin
          e.b = rf[e.r][e.l*8 +: 8];
          exp_dm[e.a[9:0]] = e.b;
        end else begin
          e.b = dm[e.a[9:0]];
          exp_rf[e.r][e.l*8 +: 8] = e.b;
        end
        q.push_back(e);
      end
    end
    @(negedge clk);
    cmd_store = st; cmd_addr = a; cmd_reg = 5'(r); cmd_lane = 2'(l); cmd_len = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done && c < 600) begin
      if (poke && c == 2) begin
        start = 1'b1; cmd_store = ~st; cmd_addr = 16'h0300; cmd_len = 8'd1;
      end
      @(negedge clk);
      start = 1'b0;
      c++;
    end
    exp_c = (exp_err != 0 || n == 0) ? 1 : EXTRA + n + 1;
    check(c == exp_c, "R7", {req, " cycles to done"}, c, exp_c);
    check(err_code == 2'(exp_err), req, "err_code", longint'(err_code), exp_err);
    check(q.size() == 0, "R1", {req, " missing beats"}, q.size(), 0);
    q.delete();
    same = 1'b1;
    for (int k = 0; k < 32; k++) if (rf[k] !== exp_rf[k]) same = 1'b0;
    check(same, "R6", {req, " register file contents"}, 0, 0);
    same = 1'b1;
    for (int k = 0; k < MEMSZ; k++) if (dm[k] !== exp_dm[k]) same = 1'b0;
    check(same, "R10", {req, " memory contents"}, 0, 0);
    @(negedge clk);
    check(!done && !busy && !mem_req, "R11", {req, " idle after done"}, longint'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++)
      rf[i] = {8'(i + 192), 8'(i + 128), 8'(i + 64), 8'(i)};
    for (int i = 0; i < MEMSZ; i++) dm[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; start = 1'b0; cmd_store = 1'b0; cmd_addr = '0; cmd_reg = '0;
    cmd_lane = '0; cmd_len = '0; null_trap_en = 1'b0; space_guard_en = 1'b0;
    code_base = 16'h0800;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R7", "reset outputs idle", longint'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: aligned load of one register
    run_cmd("R1", 1'b0, 16'h0100, 2, 0, 4, 0, 1'b0);
    // R2 R6: load from top lane crossing two register boundaries
    run_cmd("R2", 1'b0, 16'h0140, 5, 3, 6, 0, 1'b0);
    // R10: store from lane 1 crossing registers
    run_cmd("R10", 1'b1, 16'h0200, 5, 1, 7, 0, 1'b0);
    // R3: overrun by one byte, then exactly filling the file
    run_cmd("R3", 1'b0, 16'h0180, 31, 2, 3, 3, 1'b0);
    run_cmd("R3", 1'b1, 16'h0180, 31, 2, 2, 0, 1'b0);
    // R4: null trap
    null_trap_en = 1'b1;
    run_cmd("R4", 1'b0, 16'h0003, 0, 0, 1, 1, 1'b0);
    run_cmd("R4", 1'b0, 16'h0004, 1, 0, 2, 0, 1'b0);
    null_trap_en = 1'b0;
    run_cmd("R4", 1'b1, 16'h0000, 3, 2, 2, 0, 1'b0);
    // R5: instruction-space guard
    space_guard_en = 1'b1;
    run_cmd("R5", 1'b1, 16'h07FE, 4, 0, 2, 0, 1'b0);
    run_cmd("R5", 1'b1, 16'h07FE, 4, 0, 3, 2, 1'b0);
    run_cmd("R5", 1'b0, 16'h0800, 4, 0, 1, 2, 1'b0);
    space_guard_en = 1'b0;
    run_cmd("R5", 1'b0, 16'h07FE, 6, 1, 3, 0, 1'b0);
    // R8: priority between errors
    null_trap_en = 1'b1; space_guard_en = 1'b1; code_base = 16'h0001;
    run_cmd("R8", 1'b0, 16'h0002, 31, 3, 9, 1, 1'b0);
    null_trap_en = 1'b0;
    run_cmd("R8", 1'b0, 16'h0002, 31, 3, 9, 2, 1'b0);
    space_guard_en = 1'b0; code_base = 16'h0800;
    run_cmd("R8", 1'b0, 16'h0002, 31, 3, 9, 3, 1'b0);
    // R9: zero length
    run_cmd("R9", 1'b0, 16'h0120, 7, 2, 0, 0, 1'b0);
    // R11: start during a transfer is ignored
    run_cmd("R11", 1'b0, 16'h0220, 10, 2, 9, 0, 1'b1);
    run_cmd("R11", 1'b1, 16'h0260, 12, 0, 5, 0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule